// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is one execution unit of a 32-bit processor pipeline. It decodes a 32-bit instruction word and carries out one of two bit-field operations on the operands supplied with it. The extract operation selects a contiguous field of the source operand and returns it aligned to bit 0, with every bit above the field cleared. The insert operation takes the low bits of the source operand and writes them into a chosen window of the old destination value. Every destination bit outside that window keeps its old value.

The two forms encode their field in different ways. Both carry the field's low bit position (the shift) in instruction bits 4:0. The 5-bit value in bits 10:6 is the field width for extract, but the field's top bit position for insert. For insert the unit therefore rebuilds the width as top − shift + 1. Encodings that describe an impossible field raise an illegal flag and give a fixed, defined result. A parameter selects whether the outputs are registered, which puts them one clock after the input strobe, or combinational. The pipeline feeds the result and destination index to its write-back stage.

Top module: `bfu_top`

## Requirements
- R1: An instruction is accepted only when (word AND 0xFC00C000) equals 0x64004000 (extract) or 0x64008000 (insert). Bit 14 is set for extract and clear for insert. Any other word gives resValid = 0 even when inValid is high.
- R2: With each valid result, destIdx carries instruction bits 25:21.
- R3: For extract, with width W = bits 10:6 and shift S = bits 4:0, where 1 ≤ W and W + S ≤ 32, the result is (src >> S) with bits W and above cleared, and illegal = 0.
- R4: An extract with W = 0 gives illegal = 1 and result 0.
- R5: An extract with W + S > 32 gives illegal = 1 and result 0.
- R6: For insert, with top position T = bits 10:6 and shift S = bits 4:0, where T ≥ S, the result is old with bits T..S replaced by the low T − S + 1 bits of src, and illegal = 0.
- R7: An insert with T < S gives illegal = 1 and a result equal to old unchanged.
- R8: An insert with T = 31 and S = 0 replaces the whole word, so the result equals src.
- R9: With registered outputs, result, destIdx, illegal and resValid appear one clock after the inValid strobe. A cycle without inValid gives resValid = 0 on the next clock.
- R10: A synchronous active-high reset clears resValid, including when inValid is high during the reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Strobe: the instruction and operands are present |
| instrWord | input | 32 | Instruction word to decode |
| srcVal | input | 32 | Source operand |
| oldVal | input | 32 | Current value of the destination register |
| result | output | 32 | Operation result |
| destIdx | output | 5 | Destination register index |
| resValid | output | 1 | Result is valid |
| illegal | output | 1 | The field encoding was impossible |

## Verification
The hardest cases to reach are the field boundaries where the width mask is all ones or the sum of width and shift is exactly 32. A wrong comparison or an overflowing mask only shows up there. For insert, the rebuilt width comes from a subtraction, so these edges appear only when the top position and the shift meet in specific combinations. The stimulus sweeps every pair of the two 5-bit immediates for both forms, with several operand patterns, so each edge and each illegal encoding is hit directly. Opcode words that miss the pattern by a single bit, and strobes raised while reset is held, cover the paths that must stay silent.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int WID_W  = POS_W + 1;
  localparam int REG_W  = 5;

  localparam logic [WORD_W-1:0] OPC_MASK = 32'hFC00C000;
  localparam logic [WORD_W-1:0] PAT_EXT  = 32'h64004000;
  localparam logic [WORD_W-1:0] PAT_INS  = 32'h64008000;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic             opValid;
    logic             doExtract;
    logic             doInsert;
    logic             badField;
    logic [WID_W-1:0] fieldWidth;
    logic [POS_W-1:0] fieldShift;
  } bfuCtrl_t;
endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic              inValid,
  input  logic [WORD_W-1:0] instrWord,
  output bfuCtrl_t          ctrl
);
  logic [POS_W-1:0] immHi;
  logic [POS_W-1:0] immLo;
  logic             isExt;
  logic             isIns;
  logic [WID_W:0]   extSpan;
  logic             extBad;
  logic             insBad;
  logic [WID_W-1:0] insWidth;

  assign immHi = instrWord[10:6];
  assign immLo = instrWord[4:0];

  // R1: both forms share one mask and differ in bits 15:14
  assign isExt = (instrWord & OPC_MASK) == PAT_EXT;
  assign isIns = (instrWord & OPC_MASK) == PAT_INS;

  // Extract: immHi is the width; width + shift may not pass the word
  assign extSpan = (WID_W+1)'(immHi) + (WID_W+1)'(immLo);
  assign extBad  = (immHi == '0) || (extSpan > (WID_W+1)'(WORD_W));

  // Insert: immHi is the top bit position; rebuild the width
  assign insBad   = immHi < immLo;
  assign insWidth = WID_W'(immHi) - WID_W'(immLo) + WID_W'(1);

  always_comb begin
    ctrl            = '0;
    ctrl.opValid    = inValid && (isExt || isIns);
    ctrl.doExtract  = isExt;
    ctrl.doInsert   = isIns;
    ctrl.fieldShift = immLo;
    if (isExt) begin
      ctrl.badField   = extBad;
      ctrl.fieldWidth = extBad ? '0 : WID_W'(immHi);
    end else if (isIns) begin
      ctrl.badField   = insBad;
      ctrl.fieldWidth = insBad ? '0 : insWidth;
    end
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
(
  input  bfuCtrl_t          ctrl,
  input  logic [WORD_W-1:0] srcVal,
  input  logic [WORD_W-1:0] oldVal,
  output logic [WORD_W-1:0] resultComb
);
  logic [WORD_W-1:0] lowMask;
  logic [WORD_W-1:0] fieldMask;
  logic [WORD_W-1:0] extOut;
  logic [WORD_W-1:0] insOut;

  // A thermometer of fieldWidth ones, one comparator per bit
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign lowMask[i] = WID_W'(i) < ctrl.fieldWidth;
  end

  assign fieldMask = lowMask << ctrl.fieldShift;
  assign extOut    = (srcVal >> ctrl.fieldShift) & lowMask;
  assign insOut    = (oldVal & ~fieldMask) | ((srcVal & lowMask) << ctrl.fieldShift);

  always_comb begin
    resultComb = '0;
    if (ctrl.doExtract) begin
      resultComb = ctrl.badField ? '0 : extOut;
    end else if (ctrl.doInsert) begin
      resultComb = ctrl.badField ? oldVal : insOut;
    end
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [31:0]       instrWord,
  input  logic [31:0]       srcVal,
  input  logic [31:0]       oldVal,
  output logic [31:0]       result,
  output logic [4:0]        destIdx,
  output logic              resValid,
  output logic              illegal
);
  bfuCtrl_t          ctrl;
  logic [WORD_W-1:0] resultComb;

  bfu_ctrl u_ctrl (
    .inValid   (inValid),
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  bfu_datapath u_dp (
    .ctrl       (ctrl),
    .srcVal     (srcVal),
    .oldVal     (oldVal),
    .resultComb (resultComb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        resValid <= 1'b0;
      end else begin
        resValid <= ctrl.opValid;
      end
      if (ctrl.opValid) begin
        result  <= resultComb;
        destIdx <= instrWord[25:21];
        illegal <= ctrl.badField;
      end
    end

    // R9: one clock of latency on the valid path
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (resValid == $past(inValid &&
        (((instrWord & OPC_MASK) == PAT_EXT) || ((instrWord & OPC_MASK) == PAT_INS)))));

    assert_dest_index_R2: assert property (@(posedge clk) disable iff (rst)
      resValid |-> (destIdx == $past(instrWord[25:21])));

    // R4 and R5: an illegal extract yields zero
    assert_extract_bad_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (resValid && illegal && $past(instrWord[14])) |-> (result == '0));

    assert_insert_bad_keep_R7: assert property (@(posedge clk) disable iff (rst)
      (resValid && illegal && !$past(instrWord[14])) |-> (result == $past(oldVal)));

    assert_extract_high_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (resValid && !illegal && $past(instrWord[14])) |->
        ((result >> $past(instrWord[10:6])) == '0));
  end else begin : g_comb
    assign resValid = ctrl.opValid;
    assign result   = resultComb;
    assign destIdx  = instrWord[25:21];
    assign illegal  = ctrl.badField;
  end
endmodule

// File: tb/bfu_top_tb_top.sv
module bfu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] oldVal = '0;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        resValid;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bfu_top dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .srcVal(srcVal), .oldVal(oldVal), .result(result), .destIdx(destIdx),
    .resValid(resValid), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [1:0] form, input int hi, input int lo,
                                         input int rd, input int junk);
    logic [4:0] r = 5'(rd);
    logic [4:0] a = 5'(hi);
    return {6'b011001, r, a, form, 3'(junk), 5'(hi), 1'(junk >> 3), 5'(lo)};
  endfunction

  // Drive one op at the falling edge, check just after the next rising edge
  task automatic runOp(input logic [31:0] w, input logic [31:0] s, input logic [31:0] o,
                       input logic expV, input logic [31:0] expR, input logic expI,
                       input string tag);
    @(negedge clk);
    instrWord = w; srcVal = s; oldVal = o; inValid = 1'b1;
    @(posedge clk); #1;
    check({tag, " valid"}, {31'b0, resValid}, {31'b0, expV});
    if (expV) begin
      check({tag, " result"}, result, expR);
      check({tag, " illegal"}, {31'b0, illegal}, {31'b0, expI});
      check("R2 dest", {27'b0, destIdx}, {27'b0, w[25:21]});
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10 reset clears valid", {31'b0, resValid}, 32'd0);
    // R10: strobe during reset must not produce a result
    @(negedge clk);
    instrWord = mkWord(2'b01, 4, 0, 3, 0); inValid = 1'b1;
    @(posedge clk); #1;
    check("R10 strobe in reset", {31'b0, resValid}, 32'd0);
    @(negedge clk); rst = 1'b0; inValid = 1'b0;

    for (int p = 0; p < 3; p++) begin
      logic [31:0] sv = (p == 0) ? 32'hFFFFFFFF : (p == 1) ? 32'hA5C396E1 : 32'h12345678;
      logic [31:0] ov = (p == 0) ? 32'h00000000 : (p == 1) ? 32'h5A3C6B1E : 32'hFFFFFFFF;
      for (int hi = 0; hi < 32; hi++) begin
        for (int lo = 0; lo < 32; lo++) begin
          logic [63:0] m;
          logic [63:0] fm;
          logic [31:0] er;
          // Extract
          if (hi == 0) begin
            runOp(mkWord(2'b01, hi, lo, hi + lo, p + lo), sv, ov, 1'b1, '0, 1'b1, "R4 ext width0");
          end else if (hi + lo > 32) begin
            runOp(mkWord(2'b01, hi, lo, hi + lo, p + lo), sv, ov, 1'b1, '0, 1'b1, "R5 ext overflow");
          end else begin
            m  = (64'd1 << hi) - 64'd1;
            er = 32'((64'(sv) >> lo) & m);
            runOp(mkWord(2'b01, hi, lo, hi + lo, p + lo), sv, ov, 1'b1, er, 1'b0, "R3 ext");
          end
          // Insert
          if (hi < lo) begin
            runOp(mkWord(2'b10, hi, lo, hi ^ lo, p + hi), sv, ov, 1'b1, ov, 1'b1, "R7 ins bad");
          end else begin
            m  = (64'd1 << (hi - lo + 1)) - 64'd1;
            fm = m << lo;
            er = 32'((64'(ov) & ~fm) | ((64'(sv) << lo) & fm));
            if (hi == 31 && lo == 0)
              runOp(mkWord(2'b10, hi, lo, hi ^ lo, p + hi), sv, ov, 1'b1, sv, 1'b0, "R8 ins full");
            else
              runOp(mkWord(2'b10, hi, lo, hi ^ lo, p + hi), sv, ov, 1'b1, er, 1'b0, "R6 ins");
          end
        end
      end
    end

    // R1: words one bit off the patterns, plus both other values of bits 15:14
    runOp(mkWord(2'b00, 8, 4, 1, 0), 32'h1, 32'h2, 1'b0, '0, 1'b0, "R1 form00");
    runOp(mkWord(2'b11, 8, 4, 1, 0), 32'h1, 32'h2, 1'b0, '0, 1'b0, "R1 form11");
    for (int b = 26; b < 32; b++) begin
      runOp(mkWord(2'b01, 8, 4, 1, 0) ^ (32'd1 << b), 32'h1, 32'h2, 1'b0, '0, 1'b0, "R1 opcode bit");
    end

    // R9: a legal word without the strobe gives no result next clock
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      instrWord = mkWord(2'b10, 20 + k, k, k, 0); inValid = 1'b0;
      @(posedge clk); #1;
      check("R9 no strobe", {31'b0, resValid}, 32'd0);
    end

    // R10: reset while streaming
    @(negedge clk);
    instrWord = mkWord(2'b01, 3, 3, 9, 0); inValid = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check("R10 mid-run reset", {31'b0, resValid}, 32'd0);
    @(negedge clk); rst = 1'b0; inValid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule